// File: doc/BRIEF.md
# Scanline-Counting Interrupt Generator

This block counts rendered video scanlines and raises a level interrupt toward the CPU once a programmable number of lines has gone by. Software programs an 8-bit reload value, asks for a reload, and turns the interrupt on or off by writing to four register addresses. The counter moves only on a one-cycle scanline pulse that arrives while the beam is on a visible line and rendering is switched on. A video front end outside this block produces that pulse.

The counter counts down from the reload value. When it reaches zero it arms itself to reload on the next qualifying line, so it keeps firing at a fixed period without further writes. A reload value of zero switches the interrupt off completely. A reload requested during the blanking interval stays pending and is applied on the first visible qualifying line. Each register write is handled before any scanline update that falls in the same clock cycle.

Top module: `scanline_irq_gen`

## Requirements
- R1: While reset is held and after it is released, `irq_out` is low. Reset leaves the reload value at 0xFF, the counter at 0, no reload pending and the interrupt disabled. Because the counter starts at zero, the first qualifying line after the interrupt is enabled asserts `irq_out`.
- R2: A write to an address whose bits under mask 0xE001 equal 0xC000 stores `wr_data` as the reload value. A write that decodes to 0xC001 requests a reload. The next qualifying line loads the counter from the reload value. With a reload value N > 0, `irq_out` rises on the (N+1)th qualifying line counted from the request.
- R3: A qualifying line is a cycle in which `line_pulse`, `line_visible` and `render_on` are all high. A pulse with either of the other two inputs low leaves the count unchanged, and so does a cycle with no pulse.
- R4: A qualifying line that leaves the counter at zero arms a reload. The count then repeats with period N+1 lines and needs no further write.
- R5: With a reload value of zero, `irq_out` never asserts, even though the counter sits at zero.
- R6: A write that decodes to 0xE000 clears the enable and drops `irq_out` on the next cycle. While the interrupt is disabled, the counter keeps counting but does not assert `irq_out`.
- R7: `irq_out` is a level. It stays high until a write that decodes to 0xE000 or a reset. A write that decodes to 0xE001 sets the enable and does not clear an asserted `irq_out`.
- R8: A reload requested while `line_visible` is low stays pending through pulses on invisible lines. It is applied on the first visible qualifying line, using the reload value in force at that moment.
- R9: When a register write and a qualifying line fall in the same cycle, the write takes effect first. For example, a reload value written in that cycle is the one loaded by a pending reload.
- R10: Only the address bits selected by mask 0xE001 take part in decoding, so mirrored addresses behave the same as the base addresses. Writes that decode to other values (such as 0x8000, 0x8001, 0xA000 or 0xA001) have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | CPU register write strobe |
| wr_addr | input | 16 | CPU write address |
| wr_data | input | 8 | CPU write data |
| line_pulse | input | 1 | One-cycle pulse per scanline |
| line_visible | input | 1 | High while the current line is one of lines 0 to 239 |
| render_on | input | 1 | High while rendering is enabled |
| irq_out | output | 1 | Level interrupt request |

## Verification
The assertions check on every cycle that a disable write always drops the interrupt and that the interrupt holds its level except when a disable write arrives. They also check that it never rises without a qualifying line, that it only rises with a zero counter and a nonzero reload value, and that a qualifying line never leaves the counter at zero unless a reload is armed. Only the bench scenarios can show the exact line on which the interrupt fires. That covers the N+1 count, the automatic repeat period, a reload held across blanking, ordering within a single cycle, mirrored address decoding and the silence that follows a zero reload value.

// File: rtl/scanirq_pkg.sv
package scanirq_pkg;

  localparam int ADDR_W = 16;

  localparam logic [ADDR_W-1:0] DEC_MASK    = 16'hE001;
  localparam logic [ADDR_W-1:0] DEC_LATCH   = 16'hC000;
  localparam logic [ADDR_W-1:0] DEC_RELOAD  = 16'hC001;
  localparam logic [ADDR_W-1:0] DEC_OFF     = 16'hE000;
  localparam logic [ADDR_W-1:0] DEC_ON      = 16'hE001;

  typedef enum logic [2:0] {
    CMD_NONE   = 3'd0,
    CMD_LATCH  = 3'd1,
    CMD_RELOAD = 3'd2,
    CMD_OFF    = 3'd3,
    CMD_ON     = 3'd4
  } cmd_e;

endpackage

// File: rtl/scanirq_decode.sv
module scanirq_decode
  import scanirq_pkg::*;
(
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  output cmd_e              cmd
);

  logic [ADDR_W-1:0] masked;

  always_comb begin
    masked = wr_addr & DEC_MASK;
    cmd    = CMD_NONE;
    if (wr_en) begin
      unique case (masked)
        DEC_LATCH:  cmd = CMD_LATCH;
        DEC_RELOAD: cmd = CMD_RELOAD;
        DEC_OFF:    cmd = CMD_OFF;
        DEC_ON:     cmd = CMD_ON;
        default:    cmd = CMD_NONE;
      endcase
    end
  end

endmodule

// File: rtl/scanirq_core.sv
module scanirq_core
  import scanirq_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  cmd_e             cmd,
  input  logic [CNT_W-1:0] wr_data,
  input  logic             tick,
  output logic [CNT_W-1:0] latch_q,
  output logic [CNT_W-1:0] cnt_q,
  output logic             pend_q,
  output logic             hit,
  output logic             latch_nz
);

  localparam logic [CNT_W-1:0] TOP_BIT   = {1'b1, {(CNT_W-1){1'b0}}};
  localparam logic [CNT_W-1:0] LATCH_RST = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] ZERO      = '0;

  logic [CNT_W-1:0] latch_w, cnt_w;
  logic             pend_w;
  logic [CNT_W-1:0] latch_n, cnt_n;
  logic             pend_n;
  logic             latch_ce, cnt_ce, pend_ce;

  // Register writes resolved first
  always_comb begin
    latch_w = (cmd == CMD_LATCH) ? wr_data : latch_q;
    pend_w  = pend_q | (cmd == CMD_RELOAD);
    cnt_w   = (cmd == CMD_RELOAD) ? (cnt_q | TOP_BIT) : cnt_q;
  end

  // Scanline update applied on top of the written state
  always_comb begin
    latch_n = latch_w;
    cnt_n   = cnt_w;
    pend_n  = pend_w;
    hit     = 1'b0;
    if (tick) begin
      if (pend_w) begin
        cnt_n  = latch_w;
        pend_n = 1'b0;
      end else if (cnt_w != ZERO) begin
        cnt_n = cnt_w - 1'b1;
      end
      if (cnt_n == ZERO) begin
        pend_n = 1'b1;
        hit    = 1'b1;
      end
    end
    latch_nz = (latch_w != ZERO);
  end

  always_comb begin
    latch_ce = (cmd == CMD_LATCH);
    cnt_ce   = tick | (cmd == CMD_RELOAD);
    pend_ce  = tick | (cmd == CMD_RELOAD);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      latch_q <= LATCH_RST;
    end else if (latch_ce) begin
      latch_q <= latch_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= ZERO;
    end else if (cnt_ce) begin
      cnt_q <= cnt_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
    end else if (pend_ce) begin
      pend_q <= pend_n;
    end
  end

endmodule

// File: rtl/scanirq_flag.sv
module scanirq_flag
  import scanirq_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  cmd_e cmd,
  input  logic hit,
  input  logic latch_nz,
  output logic en_q,
  output logic irq_q
);

  logic en_n, irq_n;
  logic en_ce, irq_ce;

  always_comb begin
    en_n = en_q;
    if (cmd == CMD_ON)  en_n = 1'b1;
    if (cmd == CMD_OFF) en_n = 1'b0;

    irq_n = irq_q;
    if (cmd == CMD_OFF) irq_n = 1'b0;
    if (hit && en_n && latch_nz) irq_n = 1'b1;

    en_ce  = (cmd == CMD_ON) | (cmd == CMD_OFF);
    irq_ce = (cmd == CMD_OFF) | hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= 1'b0;
    end else if (en_ce) begin
      en_q <= en_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_q <= 1'b0;
    end else if (irq_ce) begin
      irq_q <= irq_n;
    end
  end

endmodule

// File: rtl/scanline_irq_gen.sv
module scanline_irq_gen
  import scanirq_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [CNT_W-1:0]  wr_data,
  input  logic              line_pulse,
  input  logic              line_visible,
  input  logic              render_on,
  output logic              irq_out
);

  cmd_e             cmd;
  logic             tick;
  logic [CNT_W-1:0] latch_q, cnt_q;
  logic             pend_q, hit, latch_nz, en_q;

  always_comb tick = line_pulse & line_visible & render_on;

  scanirq_decode u_decode (
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .cmd     (cmd)
  );

  scanirq_core #(.CNT_W(CNT_W)) u_core (
    .clk      (clk),
    .rst_n    (rst_n),
    .cmd      (cmd),
    .wr_data  (wr_data),
    .tick     (tick),
    .latch_q  (latch_q),
    .cnt_q    (cnt_q),
    .pend_q   (pend_q),
    .hit      (hit),
    .latch_nz (latch_nz)
  );

  scanirq_flag u_flag (
    .clk      (clk),
    .rst_n    (rst_n),
    .cmd      (cmd),
    .hit      (hit),
    .latch_nz (latch_nz),
    .en_q     (en_q),
    .irq_q    (irq_out)
  );

endmodule

// File: rtl/scanline_irq_gen_chk.sv
module scanline_irq_gen_chk
  import scanirq_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic              line_pulse,
  input logic              line_visible,
  input logic              render_on,
  input logic              irq_out,
  input logic [CNT_W-1:0]  latch_q,
  input logic [CNT_W-1:0]  cnt_q,
  input logic              pend_q
);

  logic c_tick, c_off;
  always_comb begin
    c_tick = line_pulse && line_visible && render_on;
    c_off  = wr_en && ((wr_addr & DEC_MASK) == DEC_OFF);
  end

  AST_OFF_DROPS_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    c_off |=> !irq_out); // R6

  AST_IRQ_IS_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out && !c_off |=> irq_out); // R7

  AST_RISE_NEEDS_LINE: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_out && !c_tick |=> !irq_out); // R3

  AST_RISE_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_out) |-> (cnt_q == '0) && (latch_q != '0)); // R5

  AST_ZERO_ARMS_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    c_tick |=> (cnt_q != '0) || pend_q); // R4

  AST_PENDING_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
    c_tick && pend_q && !wr_en |=> cnt_q == $past(latch_q)); // R2

endmodule

bind scanline_irq_gen scanline_irq_gen_chk #(.CNT_W(CNT_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .wr_en        (wr_en),
  .wr_addr      (wr_addr),
  .line_pulse   (line_pulse),
  .line_visible (line_visible),
  .render_on    (render_on),
  .irq_out      (irq_out),
  .latch_q      (latch_q),
  .cnt_q        (cnt_q),
  .pend_q       (pend_q)
);

// File: tb/scanline_irq_gen_test.sv
module scanline_irq_gen_test;

  localparam int CLK_PERIOD = 10;

  logic        clk;
  logic        rst_n;
  logic        wr_en;
  logic [15:0] wr_addr;
  logic [7:0]  wr_data;
  logic        line_pulse;
  logic        line_visible;
  logic        render_on;
  logic        irq_out;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  bit    exp_q[$];
  string tag_q[$];

  scanline_irq_gen uut (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr_en        (wr_en),
    .wr_addr      (wr_addr),
    .wr_data      (wr_data),
    .line_pulse   (line_pulse),
    .line_visible (line_visible),
    .render_on    (render_on),
    .irq_out      (irq_out)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  // Monitor: compares one expected item per clock, after the edge settles
  always @(posedge clk) begin
    #1;
    if (rst_n && exp_q.size() > 0) begin
      bit    e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      checks++;
      if (irq_out !== e) begin
        errors++;
        $display("FAIL %s: irq_out actual %b expected %b at %0t", t, irq_out, e, $time);
      end
    end
  end

  // Driver: applies one cycle of stimulus and queues the expected level
  task automatic drive(input bit pulse, input bit vis, input bit rend,
                       input bit we, input logic [15:0] addr,
                       input logic [7:0] data, input bit exp, input string tag);
    @(negedge clk);
    line_pulse   = pulse;
    line_visible = vis;
    render_on    = rend;
    wr_en        = we;
    wr_addr      = addr;
    wr_data      = data;
    exp_q.push_back(exp);
    tag_q.push_back(tag);
  endtask

  task automatic tick(input bit exp, input string tag);
    drive(1, 1, 1, 0, 16'h0000, 8'h00, exp, tag);
  endtask

  task automatic wr(input logic [15:0] addr, input logic [7:0] data,
                    input bit exp, input string tag);
    drive(0, 1, 1, 1, addr, data, exp, tag);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    errors++;
    $display("FAIL watchdog: run did not complete");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; wr_en = 0; wr_addr = 0; wr_data = 0;
    line_pulse = 0; line_visible = 0; render_on = 0;
    repeat (3) @(negedge clk);
    checks++;
    if (irq_out !== 1'b0) begin
      errors++;
      $display("FAIL R1: irq_out in reset actual %b expected 0", irq_out);
    end
    rst_n = 1'b1;

    // R1: idle after reset, then first line after enabling fires (counter starts at 0)
    drive(0, 1, 1, 0, 16'h0, 8'h0, 0, "R1");
    wr(16'hE001, 8'h00, 0, "R1");
    tick(1, "R1");
    wr(16'hE000, 8'h00, 0, "R6");

    // R2: reload value 3, request, enable -> fires on 4th line
    wr(16'hC000, 8'd3, 0, "R2");
    wr(16'hC001, 8'h00, 0, "R2");
    wr(16'hE001, 8'h00, 0, "R2");
    tick(0, "R2"); tick(0, "R2"); tick(0, "R2");
    tick(1, "R2");

    // R7: enable write and further line keep the level
    wr(16'hE001, 8'h00, 1, "R7");
    drive(0, 1, 1, 0, 16'h0, 8'h0, 1, "R7");
    tick(1, "R7");                     // reload to 3
    wr(16'hE000, 8'h00, 0, "R6");

    // R6: counting while disabled stays silent
    tick(0, "R6"); tick(0, "R6"); tick(0, "R6");   // 2,1,0
    wr(16'hE001, 8'h00, 0, "R6");
    tick(0, "R6");                     // reload to 3

    // R3: pulses that do not qualify leave the count alone
    drive(1, 0, 1, 0, 16'h0, 8'h0, 0, "R3");
    drive(1, 1, 0, 0, 16'h0, 8'h0, 0, "R3");
    drive(0, 1, 1, 0, 16'h0, 8'h0, 0, "R3");
    tick(0, "R3"); tick(0, "R3");
    tick(1, "R3");
    wr(16'hE000, 8'h00, 0, "R6");
    wr(16'hE001, 8'h00, 0, "R4");

    // R4: automatic reload, period N+1 with no request
    tick(0, "R4"); tick(0, "R4"); tick(0, "R4");
    tick(1, "R4");
    wr(16'hE000, 8'h00, 0, "R6");
    wr(16'hE001, 8'h00, 0, "R9");

    // R9: reload value written in the same cycle as the reloading line
    drive(1, 1, 1, 1, 16'hC000, 8'd1, 0, "R9");
    tick(1, "R9");
    wr(16'hE000, 8'h00, 0, "R6");
    wr(16'hE001, 8'h00, 0, "R5");

    // R5: zero reload value never fires
    wr(16'hC000, 8'd0, 0, "R5");
    for (int i = 0; i < 4; i++) tick(0, "R5");

    // R8: request during blanking, held and applied on first visible line
    wr(16'hC000, 8'd2, 0, "R8");
    tick(0, "R8");                     // reload to 2, nothing pending
    wr(16'hC000, 8'd5, 0, "R8");
    drive(0, 0, 1, 1, 16'hC001, 8'h00, 0, "R8");
    for (int i = 0; i < 3; i++) drive(1, 0, 1, 0, 16'h0, 8'h0, 0, "R8");
    for (int i = 0; i < 5; i++) tick(0, "R8");
    tick(1, "R8");
    wr(16'hE000, 8'h00, 0, "R6");

    // R10: mirrored addresses decode, others ignored
    wr(16'hDFFE, 8'd1, 0, "R10");      // reload value 1
    wr(16'h8000, 8'hFF, 0, "R10");
    wr(16'hA001, 8'hFF, 0, "R10");
    wr(16'hFFFF, 8'h00, 0, "R10");     // enable
    wr(16'hC0FF, 8'h00, 0, "R10");     // reload request
    tick(0, "R10");
    tick(1, "R10");
    wr(16'h8001, 8'h00, 1, "R10");
    wr(16'hA000, 8'h00, 1, "R10");
    wr(16'hE0FE, 8'h00, 0, "R10");     // disable

    drive(0, 1, 1, 0, 16'h0, 8'h0, 0, "R6");
    repeat (3) @(negedge clk);
    finish_run();
  end

endmodule